// File: doc/BRIEF.md
# Inclusive Cache Slice Directory

This block is the tag and coherence directory for one slice of a last-level cache that is spread over several slices. Each line of the slice carries a tag, a four-state MESI coherence state and one presence bit per core. Because the cache holds a superset of every core's private caches, the presence bits tell exactly which cores may own a copy. Coherence actions are therefore sent only to those cores, and any line that leaves the slice must be recalled from every core that has it.

Requests arrive one per cycle on a valid/ready handshake: core reads, core read-for-ownership (RFO) requests and external snoops, which either share or invalidate. Every request is answered exactly two cycles later with hit/miss, the way used, the coherence state found, the mask of cores that must be snooped and, when a fill evicts a valid line, a back-invalidate carrying the victim's line address and the cores holding it. A combinational output gives the slice number that the address hash assigns, so requesters can steer traffic. Victims come from a per-set binary tree pseudo-LRU, and invalid ways are always used first. The data array, the transport between slices and memory-side miss handling are outside this block.

Top module: `cdir_slice`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid`, `snp_mask` and `binv_valid` are 0.
- R2: `req_slice` is combinational from `req_addr`. Take the tag field, which is the address bits above the 6 line-offset bits and the set-index bits. Bit j of `req_slice` is the XOR of every tag bit whose position within the tag, modulo the slice-number width, equals j.
- R3: A request accepted at a clock edge is answered by `rsp_valid` high for exactly one cycle at the second following edge. `rsp_valid` stays low in the cycle between.
- R4: A read (`req_op`=0) that misses allocates a line in state E with only the requester's presence bit set. A read that hits adds the requester's presence bit. `rsp_hit` and `rsp_way` report the matching way.
- R5: A read hit on a line in state M sends a downgrade snoop (`snp_inv`=0) to the other cores that hold it. Other read hits send no snoop. After any read hit with other holders present, the line is in state S; with no other holder it keeps its state.
- R6: An RFO (`req_op`=1) leaves the line in M, with only the requester's presence bit set. On a hit it sends an invalidating snoop (`snp_inv`=1) to every other holder. On a miss it allocates the line.
- R7: An invalidating external snoop (`req_op`=3) that hits sends `snp_mask` equal to the line's presence bits, with `snp_inv`=1 when that mask is non-zero, and leaves the line invalid. On a miss it sends nothing, changes nothing and reports way 0.
- R8: A sharing external snoop (`req_op`=2) that hits sends `snp_mask` equal to the presence bits, with `snp_inv`=0, and leaves the line in S with its presence bits unchanged. On a miss it sends nothing and reports way 0.
- R9: When a read or RFO misses and the set holds an invalid way, the lowest-numbered invalid way is filled and no back-invalidate is issued.
- R10: When a read or RFO misses in a full set, the victim comes from a tree of decision bits numbered 1 to WAYS-1 (children of n are 2n and 2n+1). The walk starts at bit 1; a bit value of 0 selects the lower half and 1 the upper half, and the path taken spells the way number from its most significant bit. Every read or RFO updates the tree: each bit on the accessed way's path is set to point to the half that does not contain that way. Snoops leave the tree unchanged.
- R11: Evicting a valid line raises `binv_valid` with the response. `binv_addr` holds the victim's tag and set with a zero offset, and `binv_mask` holds the victim's presence bits. With no response, or no eviction, `binv_valid` and `snp_mask` are 0.
- R12: `rsp_state` gives the line's state before the access, coded I=0, S=1, E=2, M=3. A miss reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 read, 1 RFO, 2 sharing snoop, 3 invalidating snoop |
| req_core | input | CORE_W | Requesting core |
| req_addr | input | ADDR_W | Physical byte address |
| req_slice | output | SLICE_W | Hashed slice number of `req_addr` |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_state | output | 2 | State before the access |
| snp_mask | output | NUM_CORES | Cores to snoop |
| snp_inv | output | 1 | Snoop invalidates (1) or downgrades (0) |
| binv_valid | output | 1 | Back-invalidate of an evicted line |
| binv_addr | output | ADDR_W | Evicted line address |
| binv_mask | output | NUM_CORES | Cores holding the evicted line |

## Verification
The slice number is checked one time step after the address changes, with no clock involved. Every other result belongs to the response, which is due at the second rising edge after the request is accepted. The bench presents each request at a falling edge and confirms that `rsp_valid` is still low one falling edge later. It compares all response fields at the next falling edge, once both pipeline registers have updated. The bench's reference directory is updated only after that comparison, so the lookup, the victim choice and the following request's view of the new state are each checked in their own cycle.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    localparam int LINE_OFF_W = 6;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        OP_RD      = 2'd0,
        OP_RFO     = 2'd1,
        OP_SNP_SHR = 2'd2,
        OP_SNP_INV = 2'd3
    } op_e;

    // Per-request decision produced by the lookup stage
    typedef struct packed {
        logic  write;
        logic  touch;
        logic  alloc;
        logic  inv;
        mesi_e new_st;
    } action_t;

    // Fold tag bits onto out_w bits by XOR, bit i landing on i mod out_w
    function automatic logic [7:0] fold_hash(input logic [63:0] tag,
                                             input int tag_w,
                                             input int out_w);
        logic [7:0] h;
        h = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < tag_w) h = h ^ (8'(tag[i]) << (i % out_w));
        end
        return h;
    endfunction

endpackage

// File: rtl/cdir_lookup.sv
module cdir_lookup #(
    parameter int WAYS  = 16,
    parameter int TAG_W = 24,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       free_any,
    output logic [WAY_W-1:0]           free_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == key);
    end

    // Lowest index wins for both encoders
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!vld[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cdir_plru.sv
module cdir_plru #(
    parameter int WAYS = 16,
    localparam int LVL = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] tree,
    input  logic [LVL-1:0]  touch_way,
    output logic [LVL-1:0]  victim,
    output logic [WAYS-1:0] tree_next
);
    // Heap numbering from 1; bit 0 of the vector is unused and kept 0
    always_comb begin
        logic [LVL-1:0] node;
        logic [LVL-1:0] path;
        node = LVL'(1);
        path = '0;
        for (int l = 0; l < LVL; l++) begin
            path = {path[LVL-2:0], tree[node]};
            node = {node[LVL-2:0], tree[node]};
        end
        victim = path;
    end

    always_comb begin
        logic [LVL-1:0] node;
        logic [LVL-1:0] tw;
        logic           b;
        tree_next    = tree;
        tree_next[0] = 1'b0;
        node = LVL'(1);
        tw   = touch_way;
        for (int l = 0; l < LVL; l++) begin
            b               = tw[LVL-1];
            tree_next[node] = ~b;
            node            = {node[LVL-2:0], b};
            tw              = tw << 1;
        end
    end
endmodule

// File: rtl/cdir_slice.sv
module cdir_slice
    import cdir_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_CORES  = 4,
    parameter int NUM_SLICES = 4,
    parameter int NUM_SETS   = 4,
    parameter int NUM_WAYS   = 16,
    localparam int CORE_W  = $clog2(NUM_CORES),
    localparam int SLICE_W = $clog2(NUM_SLICES),
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int TAG_W   = ADDR_W - LINE_OFF_W - SET_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic [SLICE_W-1:0]   req_slice,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WAY_W-1:0]     rsp_way,
    output logic [1:0]           rsp_state,
    output logic [NUM_CORES-1:0] snp_mask,
    output logic                 snp_inv,
    output logic                 binv_valid,
    output logic [ADDR_W-1:0]    binv_addr,
    output logic [NUM_CORES-1:0] binv_mask
);
    // Directory storage
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q  [NUM_SETS];
    mesi_e                          st_q   [NUM_SETS][NUM_WAYS];
    logic [NUM_CORES-1:0]           cv_q   [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0]            tree_q [NUM_SETS];

    // Stage 1: captured request
    logic              s1_valid;
    op_e               s1_op;
    logic [CORE_W-1:0] s1_core;
    logic [SET_W-1:0]  s1_set;
    logic [TAG_W-1:0]  s1_tag;

    wire req_fire = req_valid && req_ready;

    assign req_ready = 1'b1;
    assign req_slice = SLICE_W'(fold_hash(64'(req_addr[ADDR_W-1 -: TAG_W]),
                                          TAG_W, SLICE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_RD;
            s1_core  <= '0;
            s1_set   <= '0;
            s1_tag   <= '0;
        end else begin
            s1_valid <= req_fire;
            if (req_fire) begin
                s1_op   <= op_e'(req_op);
                s1_core <= req_core;
                s1_set  <= req_addr[LINE_OFF_W +: SET_W];
                s1_tag  <= req_addr[ADDR_W-1 -: TAG_W];
            end
        end
    end

    // Stage 2: lookup and decision
    logic [NUM_WAYS-1:0] row_vld;
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_vld
        assign row_vld[w] = (st_q[s1_set][w] != ST_I);
    end

    logic             s1_hit, free_any;
    logic [WAY_W-1:0] hit_way, free_way, plru_way, sel_way;
    logic [NUM_WAYS-1:0] tree_nx;

    cdir_lookup #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lookup (
        .tags     (tag_q[s1_set]),
        .vld      (row_vld),
        .key      (s1_tag),
        .hit      (s1_hit),
        .hit_way  (hit_way),
        .free_any (free_any),
        .free_way (free_way)
    );

    cdir_plru #(.WAYS(NUM_WAYS)) u_plru (
        .tree      (tree_q[s1_set]),
        .touch_way (sel_way),
        .victim    (plru_way),
        .tree_next (tree_nx)
    );

    mesi_e                old_st;
    logic [NUM_CORES-1:0] old_cv, req_bit, others, new_cv, mask;
    action_t              act;
    logic                 evict;
    logic [WAY_W-1:0]     out_way;

    always_comb begin
        sel_way = s1_hit ? hit_way : (free_any ? free_way : plru_way);
        old_st  = s1_hit ? st_q[s1_set][hit_way] : ST_I;
        old_cv  = s1_hit ? cv_q[s1_set][hit_way] : '0;
        req_bit = NUM_CORES'(1) << s1_core;
        others  = old_cv & ~req_bit;
        act        = '0;
        act.new_st = old_st;
        new_cv     = old_cv;
        mask       = '0;
        unique case (s1_op)
            OP_RD: begin
                act.write = 1'b1;
                act.touch = 1'b1;
                if (s1_hit) begin
                    new_cv = old_cv | req_bit;
                    if (others != '0)  act.new_st = ST_S;
                    if (old_st == ST_M) mask = others;
                end else begin
                    act.alloc  = 1'b1;
                    act.new_st = ST_E;
                    new_cv     = req_bit;
                end
            end
            OP_RFO: begin
                act.write  = 1'b1;
                act.touch  = 1'b1;
                act.alloc  = !s1_hit;
                act.inv    = 1'b1;
                act.new_st = ST_M;
                new_cv     = req_bit;
                mask       = others;
            end
            OP_SNP_SHR: begin
                if (s1_hit) begin
                    act.write  = 1'b1;
                    act.new_st = ST_S;
                    mask       = old_cv;
                end
            end
            OP_SNP_INV: begin
                if (s1_hit) begin
                    act.write  = 1'b1;
                    act.inv    = 1'b1;
                    act.new_st = ST_I;
                    new_cv     = '0;
                    mask       = old_cv;
                end
            end
        endcase
        evict   = act.alloc && (st_q[s1_set][sel_way] != ST_I);
        out_way = (s1_hit || act.alloc) ? sel_way : '0;
    end

    // Response registers and directory update
    mesi_e rsp_st_q;
    assign rsp_state = rsp_st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_st_q   <= ST_I;
            snp_mask   <= '0;
            snp_inv    <= 1'b0;
            binv_valid <= 1'b0;
            binv_addr  <= '0;
            binv_mask  <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
                tree_q[s] <= '0;
                tag_q[s]  <= '0;
                for (int w = 0; w < NUM_WAYS; w++) begin
                    st_q[s][w] <= ST_I;
                    cv_q[s][w] <= '0;
                end
            end
        end else begin
            rsp_valid  <= s1_valid;
            rsp_hit    <= s1_valid && s1_hit;
            rsp_way    <= s1_valid ? out_way : '0;
            rsp_st_q   <= s1_valid ? old_st : ST_I;
            snp_mask   <= s1_valid ? mask : '0;
            snp_inv    <= s1_valid && act.inv && (mask != '0);
            binv_valid <= s1_valid && evict;
            binv_addr  <= (s1_valid && evict)
                          ? {tag_q[s1_set][sel_way], s1_set, {LINE_OFF_W{1'b0}}}
                          : '0;
            binv_mask  <= (s1_valid && evict) ? cv_q[s1_set][sel_way] : '0;
            if (s1_valid && act.write) begin
                st_q[s1_set][sel_way] <= act.new_st;
                cv_q[s1_set][sel_way] <= new_cv;
                if (act.alloc) tag_q[s1_set][sel_way] <= s1_tag;
            end
            if (s1_valid && act.touch) tree_q[s1_set] <= tree_nx;
        end
    end
endmodule

// File: rtl/cdir_slice_chk.sv
module cdir_slice_chk #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [1:0]           rsp_state,
    input logic [NUM_CORES-1:0] snp_mask,
    input logic                 snp_inv,
    input logic                 binv_valid,
    input logic [NUM_CORES-1:0] binv_mask,
    input logic [1:0]           s1_op,
    input logic [CORE_W-1:0]    s1_core
);
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready, 2));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (snp_mask == '0 && !binv_valid));

    p_binv_on_miss_r11: assert property (@(posedge clk) disable iff (rst)
        binv_valid |-> (!rsp_hit && binv_mask != '0));

    p_no_self_snoop_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(s1_op[1]))
            |-> ((snp_mask & (NUM_CORES'(1) << $past(s1_core))) == '0));

    p_inv_has_target_r7: assert property (@(posedge clk) disable iff (rst)
        snp_inv |-> (snp_mask != '0));

    p_miss_state_r12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_state == 2'd0));
endmodule

bind cdir_slice cdir_slice_chk #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_state  (rsp_state),
    .snp_mask   (snp_mask),
    .snp_inv    (snp_inv),
    .binv_valid (binv_valid),
    .binv_mask  (binv_mask),
    .s1_op      (s1_op),
    .s1_core    (s1_core)
);

// File: tb/cdir_slice_test.sv
module cdir_slice_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_core = 2'd0;
    logic [31:0] req_addr = 32'd0;
    logic [1:0]  req_slice;
    logic        rsp_valid, rsp_hit, snp_inv, binv_valid;
    logic [3:0]  rsp_way;
    logic [1:0]  rsp_state;
    logic [3:0]  snp_mask, binv_mask;
    logic [31:0] binv_addr;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #(CLK_P/2) clk = ~clk;

    cdir_slice uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_core(req_core), .req_addr(req_addr),
        .req_slice(req_slice), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_state(rsp_state), .snp_mask(snp_mask),
        .snp_inv(snp_inv), .binv_valid(binv_valid), .binv_addr(binv_addr),
        .binv_mask(binv_mask)
    );

    // Reference directory
    logic [23:0] m_tag  [4][16];
    logic [1:0]  m_st   [4][16];
    logic [3:0]  m_cv   [4][16];
    logic [15:0] m_tree [4];
    logic [31:0] lfsr = 32'h1234_5679;

    task automatic chk(input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_slice(input logic [23:0] t);
        logic [1:0] h = 2'd0;
        for (int i = 0; i < 24; i++) h = h ^ (2'(t[i]) << (i % 2));
        return h;
    endfunction

    function automatic int tree_victim(input logic [15:0] t);
        int node = 1;
        int path = 0;
        for (int l = 0; l < 4; l++) begin
            path = path * 2 + int'(t[node]);
            node = node * 2 + int'(t[node]);
        end
        return path;
    endfunction

    function automatic logic [15:0] tree_touch(input logic [15:0] t, input int w);
        int node = 1;
        int b;
        for (int l = 0; l < 4; l++) begin
            b = (w >> (3 - l)) & 1;
            t[node] = (b == 0);
            node = node * 2 + b;
        end
        return t;
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic issue(input logic [1:0] op, input int set,
                         input logic [23:0] tag, input int core);
        logic        hit = 0, had_free = 0, alloc = 0, wr = 0, touch = 0;
        logic        inv = 0, bv;
        int          way = 0;
        logic [1:0]  ost, nst;
        logic [3:0]  ocv, rb, oth, ncv, mask = 4'd0, bm;
        logic [31:0] ba;
        string       lh, lm, lw;
        for (int w = 0; w < 16; w++)
            if (!hit && m_st[set][w] != 2'd0 && m_tag[set][w] == tag) begin
                hit = 1; way = w;
            end
        if (!hit) begin
            for (int w = 0; w < 16; w++)
                if (!had_free && m_st[set][w] == 2'd0) begin
                    had_free = 1; way = w;
                end
            if (!had_free) way = tree_victim(m_tree[set]);
        end
        ost = hit ? m_st[set][way] : 2'd0;
        ocv = hit ? m_cv[set][way] : 4'd0;
        rb  = 4'(1 << core);
        oth = ocv & ~rb;
        nst = ost;
        ncv = ocv;
        case (op)
            2'd0: begin
                lh = "R4"; lm = "R5"; wr = 1; touch = 1;
                if (hit) begin
                    ncv = ocv | rb;
                    if (oth != 0) nst = 2'd1;
                    if (ost == 2'd3) mask = oth;
                end else begin
                    alloc = 1; nst = 2'd2; ncv = rb;
                end
            end
            2'd1: begin
                lh = "R6"; lm = "R6"; wr = 1; touch = 1; alloc = !hit;
                nst = 2'd3; ncv = rb; mask = oth; inv = (oth != 0);
            end
            2'd2: begin
                lh = "R8"; lm = "R8";
                if (hit) begin wr = 1; nst = 2'd1; mask = ocv; end
            end
            default: begin
                lh = "R7"; lm = "R7";
                if (hit) begin
                    wr = 1; nst = 2'd0; ncv = 4'd0; mask = ocv; inv = (ocv != 0);
                end
            end
        endcase
        if (!hit && !alloc) way = 0;
        lw = hit ? lh : (alloc ? (had_free ? "R9" : "R10") : lh);
        bv = alloc && m_st[set][way] != 2'd0;
        ba = bv ? {m_tag[set][way], 2'(set), 6'd0} : 32'd0;
        bm = bv ? m_cv[set][way] : 4'd0;

        req_valid = 1'b1;
        req_op    = op;
        req_core  = 2'(core);
        req_addr  = {tag, 2'(set), 6'd0};
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "rsp_valid early", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk("R3", "rsp_valid due", 64'(rsp_valid), 64'd1);
        chk(lh, "rsp_hit", 64'(rsp_hit), 64'(hit));
        chk(lw, "rsp_way", 64'(rsp_way), 64'(way));
        chk("R12", "rsp_state", 64'(rsp_state), 64'(ost));
        chk(lm, "snp_mask", 64'(snp_mask), 64'(mask));
        chk(lm, "snp_inv", 64'(snp_inv), 64'(inv));
        chk("R11", "binv_valid", 64'(binv_valid), 64'(bv));
        chk("R11", "binv_addr", 64'(binv_addr), 64'(ba));
        chk("R11", "binv_mask", 64'(binv_mask), 64'(bm));

        if (wr) begin
            m_st[set][way] = nst;
            m_cv[set][way] = ncv;
            if (alloc) m_tag[set][way] = tag;
        end
        if (touch) m_tree[set] = tree_touch(m_tree[set], way);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            m_tree[s] = 16'd0;
            for (int w = 0; w < 16; w++) begin
                m_st[s][w] = 2'd0; m_cv[s][w] = 4'd0; m_tag[s][w] = 24'd0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "snp_mask", 64'(snp_mask), 64'd0);
        chk("R1", "binv_valid", 64'(binv_valid), 64'd0);

        // R2: slice hash over many addresses, no request
        for (int i = 0; i < 300; i++) begin
            step_lfsr();
            req_addr = lfsr;
            #1;
            chk("R2", "req_slice", 64'(req_slice), 64'(exp_slice(lfsr[31:8])));
        end
        @(negedge clk);
        chk("R1", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R9: fill every way of every set from empty (reset left all invalid)
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 16; w++)
                issue(2'd0, s, 24'(w * 7919 + 3), w % 4);

        // Mixed traffic over a tag pool larger than a set
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] op;
            step_lfsr();
            case (lfsr[12:10])
                3'd0:    op = 2'd3;
                3'd1:    op = 2'd2;
                default: op = lfsr[8] ? 2'd1 : 2'd0;
            endcase
            issue(op, int'(lfsr[1:0]), 24'((int'(lfsr[6:2]) % 20) * 7919 + 3),
                  int'(lfsr[14:13]));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule